// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-input programmable interrupt controller. It keeps registered copies of the request vector, the per-input mask bits and the in-service bits, and a pointer that names the input with the lowest priority. Every cycle it makes two combinational choices from that state. The first is the best pending request that may be raised to the processor. The second is the in-service input that an end-of-interrupt without a level would retire.

Commands reach the block already decoded: an acknowledge strobe that moves the current winner into service, and a command strobe with EOI, specific and rotate flags and a level field. These commands carry out end-of-interrupt, priority rotation and priority setting. Two modes change how in-service bits hold back new requests. In special mask mode they are ignored during selection. In special fully-nested mode, which only a master instance honours, the cascade input can be requested again while it is still in service. Bus decode, edge detection and cascading are handled by other blocks.

Top module: `irq_prio_resolver`

## Requirements
- R1: After a synchronous active-low reset, the request, mask and in-service registers are zero, special mask mode is off and the lowest-priority pointer `low_prio` is 7. So `int_valid` and `isr_valid` are 0, and input 0 has the highest priority.
- R2: `req_in` is registered on every clock. `mask_in` is registered on a clock where `mask_we` is 1. `int_valid`/`int_pin` follow from the registers. The scan starts at input (`low_prio`+1) mod 8 and wraps through all eight inputs. The winner is the first input whose request bit is 1 and whose mask bit is 0. A change on `req_in` shows at the outputs one clock after it is driven.
- R3: With special mask mode off, the scan ends with no winner at the first input whose in-service bit is 1, when that comes before any eligible request. This includes the case where that same input is also requesting.
- R4: Special mask mode is loaded from `smm_in` on a clock where `smm_we` is 1. While it is on, the in-service bits play no part in choosing `int_pin`, and only the mask bits gate requests.
- R5: When `sfnm_en` is 1 on a master instance (`IS_MASTER`=1), the in-service bit of the cascade input (`CASC_PIN`, default 2) does not stop the scan.
- R6: An `ack` pulse while `int_valid` is 1 sets the in-service bit of `int_pin` at the next clock. An `ack` while `int_valid` is 0 changes nothing.
- R7: `isr_valid`/`isr_pin` give the first in-service input in scan order. In special mask mode, an in-service input whose mask bit is 1 is skipped.
- R8: A command with `cmd_eoi`=1 and `cmd_spec`=0 (non-specific EOI) clears the in-service bit at `isr_pin`. With `cmd_rot`=1 it also loads `low_prio` with that pin.
- R9: A command with `cmd_eoi`=1 and `cmd_spec`=1 (specific EOI) clears the in-service bit selected by `cmd_level`. With `cmd_rot`=1 it also loads `low_prio` with `cmd_level`.
- R10: A command with `cmd_eoi`=0, `cmd_spec`=1 and `cmd_rot`=1 (set priority) loads `low_prio` from `cmd_level`. Any other command with `cmd_eoi`=0 leaves `low_prio` and the in-service bits unchanged.
- R11: A non-specific EOI while `isr_valid` is 0 leaves the in-service bits and `low_prio` unchanged, even with `cmd_rot`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 8 | Request vector, registered every clock |
| mask_we | input | 1 | Load the mask register |
| mask_in | input | 8 | New mask bits, 1 disables the input |
| smm_we | input | 1 | Load the special-mask-mode flag |
| smm_in | input | 1 | New special-mask-mode flag |
| sfnm_en | input | 1 | Special fully-nested mode (honoured on a master only) |
| ack | input | 1 | Acknowledge: move the current winner into service |
| cmd_valid | input | 1 | Command strobe |
| cmd_eoi | input | 1 | Command is an end-of-interrupt |
| cmd_spec | input | 1 | Command uses `cmd_level` |
| cmd_rot | input | 1 | Command rotates or sets priority |
| cmd_level | input | 3 | Input number used by the command |
| int_valid | output | 1 | A pending request is eligible |
| int_pin | output | 3 | Input number of the eligible request |
| isr_valid | output | 1 | An in-service input can be retired by a non-specific EOI |
| isr_pin | output | 3 | Input that a non-specific EOI would retire |
| isr_vec | output | 8 | Current in-service bits |
| low_prio | output | 3 | Current lowest-priority input |

## Verification
A pointer that is off by one, or wraps the wrong way, changes `int_pin` and `isr_pin` in the same cycle for most request patterns. That is why every stored pattern is replayed under all eight pointer values. A stale or wrongly cleared in-service bit does not change `isr_vec` alone: from the next clock it also blocks or releases `int_valid`, and it shifts the retire choice on `isr_pin`. A mode flag taking the wrong effect shows only when some in-service bit comes before a request in scan order. The stored cases are built to put in-service bits there.

// File: rtl/irq_prio_pkg.sv
// Shared types for the rotating-priority interrupt resolver.
// Assumes: command flags arrive already qualified by a strobe.
package irq_prio_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_EOI_NS = 2'd1,
        OP_EOI_SP = 2'd2,
        OP_SETPRI = 2'd3
    } prio_op_e;

    // Map the decoded command flags onto one operation.
    function automatic prio_op_e decode_op(input logic valid, input logic eoi,
                                           input logic spec, input logic rot);
        prio_op_e op;
        op = OP_NONE;
        if (valid) begin
            if (eoi)
                op = spec ? OP_EOI_SP : OP_EOI_NS;
            else if (spec && rot)
                op = OP_SETPRI;
        end
        return op;
    endfunction

endpackage

// File: rtl/prio_scan.sv
// Wrapping priority scan. Starting at index 'base', it walks all N inputs
// in order. It stops at the first input that is a blocker (no hit) or a
// candidate (hit). A blocker takes precedence over a candidate at the same
// index. Assumes: N is a power of two, so the index wraps by truncation.
module prio_scan #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    input  logic [N-1:0] blk,
    input  logic [W-1:0] base,
    output logic         hit,
    output logic [W-1:0] pin
);

    // Walk from the highest priority down and stop at the first decision.
    always_comb begin
        logic         stop;
        logic [W-1:0] idx;
        hit  = 1'b0;
        pin  = '0;
        stop = 1'b0;
        idx  = '0;
        for (int i = 0; i < N; i++) begin
            idx = base + W'(i);
            if (!stop) begin
                if (blk[idx]) begin
                    stop = 1'b1;
                end else if (cand[idx]) begin
                    hit  = 1'b1;
                    pin  = idx;
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/prio_state.sv
// State of the resolver: request, mask and in-service registers, the
// special-mask-mode flag and the lowest-priority pointer. It applies
// acknowledge and EOI / priority commands. Assumes: isr_pin / int_pin are
// the current-cycle selections from the scanners. When acknowledge and EOI
// touch the same bit in one cycle, the acknowledge set wins.
module prio_state
    import irq_prio_pkg::*;
#(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic         mask_we,
    input  logic [N-1:0] mask_in,
    input  logic         smm_we,
    input  logic         smm_in,
    input  logic         ack,
    input  logic         int_valid,
    input  logic [W-1:0] int_pin,
    input  prio_op_e     op,
    input  logic         rot,
    input  logic [W-1:0] level,
    input  logic         isr_valid,
    input  logic [W-1:0] isr_pin,
    output logic [N-1:0] req_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] isr_q,
    output logic [W-1:0] low_q,
    output logic         smm_q
);

    localparam logic [W-1:0] LOW_RESET = W'(N - 1);

    logic [N-1:0] isr_clr;
    logic [N-1:0] isr_set;
    logic [W-1:0] low_d;

    // Work out which in-service bit a command retires and the new pointer.
    always_comb begin
        isr_clr = '0;
        low_d   = low_q;
        unique case (op)
            OP_EOI_NS: begin
                if (isr_valid) begin
                    isr_clr[isr_pin] = 1'b1;
                    if (rot) low_d = isr_pin;
                end
            end
            OP_EOI_SP: begin
                isr_clr[level] = 1'b1;
                if (rot) low_d = level;
            end
            OP_SETPRI: low_d = level;
            default: ;
        endcase
    end

    // Acknowledge moves the current winner into service.
    always_comb begin
        isr_set = '0;
        if (ack && int_valid) isr_set[int_pin] = 1'b1;
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            mask_q <= '0;
            isr_q  <= '0;
            low_q  <= LOW_RESET;
            smm_q  <= 1'b0;
        end else begin
            req_q <= req_in;
            if (mask_we) mask_q <= mask_in;
            if (smm_we)  smm_q  <= smm_in;
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            low_q <= low_d;
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
// Top of the rotating-priority interrupt resolver. It builds the blocking
// vector for the pending scan from the mode flags, and runs two wrapping
// scans that start one past the lowest-priority pointer. Assumes: N_IN is a
// power of two, and CASC_PIN < N_IN. sfnm_en has an effect only when
// IS_MASTER is 1.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int N_IN      = 8,
    parameter bit IS_MASTER = 1'b1,
    parameter int CASC_PIN  = 2,
    localparam int W        = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] req_in,
    input  logic            mask_we,
    input  logic [N_IN-1:0] mask_in,
    input  logic            smm_we,
    input  logic            smm_in,
    input  logic            sfnm_en,
    input  logic            ack,
    input  logic            cmd_valid,
    input  logic            cmd_eoi,
    input  logic            cmd_spec,
    input  logic            cmd_rot,
    input  logic [W-1:0]    cmd_level,
    output logic            int_valid,
    output logic [W-1:0]    int_pin,
    output logic            isr_valid,
    output logic [W-1:0]    isr_pin,
    output logic [N_IN-1:0] isr_vec,
    output logic [W-1:0]    low_prio
);

    logic [N_IN-1:0] req_q, mask_q, isr_q;
    logic [W-1:0]    low_q;
    logic            smm_q;
    logic [W-1:0]    scan_base;
    logic [N_IN-1:0] pend_cand, pend_blk;
    logic [N_IN-1:0] eoi_cand;
    prio_op_e        op;

    // Decode the command strobe into one operation.
    assign op = decode_op(cmd_valid, cmd_eoi, cmd_spec, cmd_rot);

    // The highest priority sits one past the lowest-priority pointer.
    assign scan_base = low_q + W'(1);

    // Eligible requests: requested and not masked.
    assign pend_cand = req_q & ~mask_q;

    // Per-input blocking: in-service bits, waived by the mode flags.
    for (genvar g = 0; g < N_IN; g++) begin : g_blk
        if (IS_MASTER && g == CASC_PIN) begin : g_casc
            assign pend_blk[g] = isr_q[g] & ~smm_q & ~sfnm_en;
        end else begin : g_plain
            logic unused_sfnm;
            assign unused_sfnm = sfnm_en;
            assign pend_blk[g] = isr_q[g] & ~smm_q;
        end
    end

    // EOI candidates: in-service bits, minus masked ones in special mask mode.
    assign eoi_cand = isr_q & ~(smm_q ? mask_q : '0);

    prio_state #(.N(N_IN), .W(W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .mask_we   (mask_we),
        .mask_in   (mask_in),
        .smm_we    (smm_we),
        .smm_in    (smm_in),
        .ack       (ack),
        .int_valid (int_valid),
        .int_pin   (int_pin),
        .op        (op),
        .rot       (cmd_rot),
        .level     (cmd_level),
        .isr_valid (isr_valid),
        .isr_pin   (isr_pin),
        .req_q     (req_q),
        .mask_q    (mask_q),
        .isr_q     (isr_q),
        .low_q     (low_q),
        .smm_q     (smm_q)
    );

    prio_scan #(.N(N_IN), .W(W)) u_pend_scan (
        .cand (pend_cand),
        .blk  (pend_blk),
        .base (scan_base),
        .hit  (int_valid),
        .pin  (int_pin)
    );

    prio_scan #(.N(N_IN), .W(W)) u_eoi_scan (
        .cand (eoi_cand),
        .blk  ('0),
        .base (scan_base),
        .hit  (isr_valid),
        .pin  (isr_pin)
    );

    assign isr_vec  = isr_q;
    assign low_prio = low_q;

endmodule

// File: rtl/irq_prio_checker.sv
// Temporal checks for the resolver, bound to every instance of the top.
// Assumes: the bind connects the top's registers and selections by name.
module irq_prio_checker #(
    parameter int N_IN = 8,
    parameter int W    = $clog2(N_IN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            int_valid,
    input logic [W-1:0]    int_pin,
    input logic            isr_valid,
    input logic [W-1:0]    isr_pin,
    input logic [N_IN-1:0] req_q,
    input logic [N_IN-1:0] mask_q,
    input logic [N_IN-1:0] isr_q,
    input logic [W-1:0]    low_q,
    input logic            ack,
    input logic            cmd_valid,
    input logic            cmd_eoi,
    input logic            cmd_spec,
    input logic            cmd_rot,
    input logic [W-1:0]    cmd_level
);

    assert_winner_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> (req_q[int_pin] && !mask_q[int_pin]));

    assert_ack_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_valid && !cmd_valid) |=> isr_q[$past(int_pin)]);

    assert_retire_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        isr_valid |-> isr_q[isr_pin]);

    assert_ns_rotate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_eoi && !cmd_spec && cmd_rot && isr_valid && !ack)
        |=> (low_q == $past(isr_pin)) && !isr_q[$past(isr_pin)]);

    assert_spec_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_eoi && cmd_spec && !ack) |=> !isr_q[$past(cmd_level)]);

    assert_set_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_eoi && cmd_spec && cmd_rot) |=> (low_q == $past(cmd_level)));

    assert_empty_eoi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_eoi && !cmd_spec && !isr_valid && !ack)
        |=> ($stable(isr_q) && $stable(low_q)));

endmodule

bind irq_prio_resolver irq_prio_checker #(.N_IN(N_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_valid (int_valid),
    .int_pin   (int_pin),
    .isr_valid (isr_valid),
    .isr_pin   (isr_pin),
    .req_q     (req_q),
    .mask_q    (mask_q),
    .isr_q     (isr_q),
    .low_q     (low_q),
    .ack       (ack),
    .cmd_valid (cmd_valid),
    .cmd_eoi   (cmd_eoi),
    .cmd_spec  (cmd_spec),
    .cmd_rot   (cmd_rot),
    .cmd_level (cmd_level)
);

// File: tb/test_irq_prio_resolver.sv
// Bench: a table of request/mask/in-service/mode patterns replayed under
// every pointer value, then directed tests for reset, commands and corners.
module test_irq_prio_resolver;

    localparam int CLK_HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0, mask_in = '0;
    logic       mask_we = 0, smm_we = 0, smm_in = 0, sfnm_en = 0, ack = 0;
    logic       cmd_valid = 0, cmd_eoi = 0, cmd_spec = 0, cmd_rot = 0;
    logic [2:0] cmd_level = '0;
    logic       int_valid, isr_valid;
    logic [2:0] int_pin, isr_pin, low_prio;
    logic [7:0] isr_vec;

    int n_run = 0;
    int n_fail = 0;

    always #CLK_HALF clk = ~clk;

    irq_prio_resolver i_irq_prio_resolver (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_we(mask_we),
        .mask_in(mask_in), .smm_we(smm_we), .smm_in(smm_in), .sfnm_en(sfnm_en),
        .ack(ack), .cmd_valid(cmd_valid), .cmd_eoi(cmd_eoi), .cmd_spec(cmd_spec),
        .cmd_rot(cmd_rot), .cmd_level(cmd_level), .int_valid(int_valid),
        .int_pin(int_pin), .isr_valid(isr_valid), .isr_pin(isr_pin),
        .isr_vec(isr_vec), .low_prio(low_prio)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] mask;
        logic [7:0] isr;
        logic       smm;
        logic       sfnm;
    } vec_t;

    localparam vec_t TBL [16] = '{
        '{8'hff, 8'h00, 8'h00, 1'b0, 1'b0},
        '{8'h81, 8'h01, 8'h00, 1'b0, 1'b0},
        '{8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        '{8'hf0, 8'h00, 8'h08, 1'b0, 1'b0},
        '{8'h5a, 8'h12, 8'h20, 1'b0, 1'b0},
        '{8'hff, 8'hff, 8'h00, 1'b0, 1'b0},
        '{8'h3c, 8'h00, 8'h04, 1'b0, 1'b1},
        '{8'h3c, 8'h00, 8'h04, 1'b0, 1'b0},
        '{8'h0f, 8'h03, 8'h44, 1'b1, 1'b0},
        '{8'ha5, 8'h00, 8'hff, 1'b0, 1'b0},
        '{8'ha5, 8'h20, 8'ha5, 1'b1, 1'b0},
        '{8'h04, 8'h00, 8'h04, 1'b0, 1'b1},
        '{8'h04, 8'h00, 8'h04, 1'b0, 1'b0},
        '{8'h80, 8'h7f, 8'h01, 1'b0, 1'b0},
        '{8'hc3, 8'h81, 8'h18, 1'b1, 1'b1},
        '{8'h11, 8'h00, 8'h10, 1'b0, 1'b0}
    };

    // Reference pending scan: {valid, pin}.
    function automatic logic [3:0] ref_pend(logic [7:0] rq, logic [7:0] mk,
            logic [7:0] is, logic [2:0] lp, logic smm, logic sfnm);
        for (int k = 0; k < 8; k++) begin
            logic [2:0] p;
            p = 3'(lp + 3'd1 + 3'(k));
            if (is[p] && !smm && !(sfnm && p == 3'd2)) return 4'h0;
            if (rq[p] && !mk[p]) return {1'b1, p};
        end
        return 4'h0;
    endfunction

    // Reference EOI scan: {valid, pin}.
    function automatic logic [3:0] ref_isr(logic [7:0] mk, logic [7:0] is,
            logic [2:0] lp, logic smm);
        for (int k = 0; k < 8; k++) begin
            logic [2:0] p;
            p = 3'(lp + 3'd1 + 3'(k));
            if (is[p] && !(smm && mk[p])) return {1'b1, p};
        end
        return 4'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_cmd(logic e, logic s, logic r, logic [2:0] lv);
        cmd_valid = 1; cmd_eoi = e; cmd_spec = s; cmd_rot = r; cmd_level = lv;
        tick();
        cmd_valid = 0; cmd_eoi = 0; cmd_spec = 0; cmd_rot = 0;
    endtask

    task automatic set_cfg(logic [7:0] rq, logic [7:0] mk, logic smm, logic sfnm);
        req_in = rq; mask_we = 1; mask_in = mk; smm_we = 1; smm_in = smm;
        sfnm_en = sfnm;
        tick();
        mask_we = 0; smm_we = 0;
    endtask

    // Clear all in-service bits, then move each wanted bit into service.
    task automatic build_isr(logic [7:0] want);
        for (int b = 0; b < 8; b++) do_cmd(1'b1, 1'b1, 1'b0, 3'(b));
        for (int b = 0; b < 8; b++) begin
            if (want[b]) begin
                set_cfg(8'(1 << b), ~8'(1 << b), 1'b1, 1'b0);
                ack = 1;
                tick();
                ack = 0;
            end
        end
    endtask

    initial begin
        #(2 * CLK_HALF * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 int_valid", 32'(int_valid), 32'd0);
        check("R1 isr_valid", 32'(isr_valid), 32'd0);
        check("R1 isr_vec", 32'(isr_vec), 32'd0);
        check("R1 low_prio", 32'(low_prio), 32'd7);

        // Table walk: every pattern under every pointer value (R2..R5, R7)
        for (int t = 0; t < 16; t++) begin
            for (int lp = 0; lp < 8; lp++) begin
                logic [3:0] ep, ei;
                string tag;
                build_isr(TBL[t].isr);
                do_cmd(1'b0, 1'b1, 1'b1, 3'(lp));
                set_cfg(TBL[t].req, TBL[t].mask, TBL[t].smm, TBL[t].sfnm);
                ep = ref_pend(TBL[t].req, TBL[t].mask, TBL[t].isr, 3'(lp),
                              TBL[t].smm, TBL[t].sfnm);
                ei = ref_isr(TBL[t].mask, TBL[t].isr, 3'(lp), TBL[t].smm);
                if (TBL[t].smm) tag = "R4 pending";
                else if (TBL[t].sfnm) tag = "R5 pending";
                else if (TBL[t].isr != 0) tag = "R3 pending";
                else tag = "R2 pending";
                check(tag, {int_valid, int_valid ? int_pin : 3'd0}, 32'(ep));
                check("R7 retire pick", {isr_valid, isr_valid ? isr_pin : 3'd0}, 32'(ei));
            end
        end

        // R6 ack with nothing eligible
        build_isr(8'h00);
        set_cfg(8'h00, 8'hff, 1'b0, 1'b0);
        ack = 1; tick(); ack = 0;
        check("R6 ack ignored", 32'(isr_vec), 32'h00);

        // R11 non-specific EOI with empty in-service
        do_cmd(1'b0, 1'b1, 1'b1, 3'd5);
        do_cmd(1'b1, 1'b0, 1'b1, 3'd0);
        check("R11 low_prio", 32'(low_prio), 32'd5);
        check("R11 isr_vec", 32'(isr_vec), 32'h00);

        // R8 non-specific EOI with and without rotate
        build_isr(8'h42);
        set_cfg(8'h00, 8'h00, 1'b0, 1'b0);
        do_cmd(1'b0, 1'b1, 1'b1, 3'd7);
        do_cmd(1'b1, 1'b0, 1'b1, 3'd0);
        check("R8 rotate isr_vec", 32'(isr_vec), 32'h40);
        check("R8 rotate low_prio", 32'(low_prio), 32'd1);
        check("R8 next pick", 32'(isr_pin), 32'd6);
        do_cmd(1'b1, 1'b0, 1'b0, 3'd0);
        check("R8 plain isr_vec", 32'(isr_vec), 32'h00);
        check("R8 plain low_prio", 32'(low_prio), 32'd1);

        // R9 specific EOI with and without rotate
        build_isr(8'h24);
        set_cfg(8'h00, 8'h00, 1'b0, 1'b0);
        do_cmd(1'b1, 1'b1, 1'b1, 3'd5);
        check("R9 rotate isr_vec", 32'(isr_vec), 32'h04);
        check("R9 rotate low_prio", 32'(low_prio), 32'd5);
        do_cmd(1'b1, 1'b1, 1'b0, 3'd2);
        check("R9 plain isr_vec", 32'(isr_vec), 32'h00);
        check("R9 plain low_prio", 32'(low_prio), 32'd5);

        // R10 set priority, and commands without EOI that do nothing
        do_cmd(1'b0, 1'b1, 1'b0, 3'd3);
        check("R10 spec only", 32'(low_prio), 32'd5);
        do_cmd(1'b0, 1'b0, 1'b1, 3'd3);
        check("R10 rot only", 32'(low_prio), 32'd5);
        do_cmd(1'b0, 1'b1, 1'b1, 3'd3);
        check("R10 set", 32'(low_prio), 32'd3);

        // R7 special mask mode skips a masked in-service bit on EOI
        build_isr(8'h03);
        do_cmd(1'b0, 1'b1, 1'b1, 3'd7);
        set_cfg(8'h00, 8'h01, 1'b1, 1'b0);
        check("R7 smm pick", 32'(isr_pin), 32'd1);
        do_cmd(1'b1, 1'b0, 1'b0, 3'd0);
        check("R7 smm isr_vec", 32'(isr_vec), 32'h01);

        // R2 one-clock latency from req_in
        build_isr(8'h00);
        set_cfg(8'h00, 8'h00, 1'b0, 1'b0);
        req_in = 8'h10;
        #1;
        check("R2 before clock", 32'(int_valid), 32'd0);
        tick();
        check("R2 after clock", {int_valid, int_pin}, 32'h0c);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule